// File: doc/BRIEF.md
# Multiplexed Bus Cycle Strobe Generator

This block turns a single bus request into a complete multiplexed address/data bus cycle. The request is a kind (one of seven 3-bit codes), an address and write data. The cycle runs through the T-states T1, T2, T3, zero or more wait states TW, and T4. The block runs on a clock at twice the T-state rate and keeps a phase bit, so every T-state has a first half and a second half. Each strobe edge therefore falls either on a T-state boundary or exactly at its middle.

The cycle kind sets which read, write or acknowledge strobe fires and whether the transceiver enable opens early. It also sets the memory/I-O select, the transceiver direction and the 3-bit status code. The first half of T4 can take the next request, so back-to-back cycles need no idle states. An external master can ask for the bus while the block is idle. The block answers with a grant in the middle of an idle T-state and withdraws the output enables of everything except the address strobe. Pads are not part of the block: it only provides the output-enable signals `ad_oe` and `ctl_oe`.

Top module: `bus_strobe_gen`

## Requirements
- R1: A request is taken (`req_accept` high at a clock edge) only in the first half of an idle T-state or of T4, and only while `ext_req` is low. A request whose kind is 111 is never taken.
- R2: Each taken request is followed by this sequence of clock periods: one lead half-state, then two halves each of T1, T2 and T3, then two halves per wait state, then two halves of T4. `addr_strobe` is high in the first half of T1 only, and never during a hold.
- R3: The strobe pins are active low. `rd_strb_n` is low from the start of T2 to the end of the last T3/TW for kinds 001, 100 and 101. `wr_strb_n` is low over the same window for kinds 010 and 110. `ack_strb_n` is low over the same window for kind 000. Kind 011 (halt) drives no strobe.
- R4: For every kind except 011, `xcvr_en_n` is low until the middle of T4. It goes low at the start of T2 for write kinds, and at the middle of T2 for read and acknowledge kinds.
- R5: From the lead half through the first half of T4, `mem_sel` equals kind bit 2 (1 = memory, 0 = I/O). Over the same span, `xcvr_tx` is 1 for write kinds and 0 otherwise.
- R6: `cyc_status` carries the kind code from the lead half through the first half of T3. It stays at the kind code while `bus_rdy` is still being sampled low, turns to 111 in the second half of the T3/TW in which `bus_rdy` was sampled high, and reads 111 during T4 and when idle.
- R7: `bus_rdy` is sampled at the middle of T3 and at the middle of every TW. Each low sample adds exactly one TW before T4.
- R8: `ad_oe` is high in T1, where `ad_out` carries the low address bits. For write kinds, `ad_oe` stays high from T2 through T4 and `ad_out` carries the write data. In T1, `a_hi` carries the upper address bits for memory kinds and is zero for I/O kinds.
- R9: `ext_req` is honoured only from idle. `ext_grant` rises in the middle of an idle T-state, and while it is high `ctl_oe` and `ad_oe` are low and no request is taken. `ext_grant` falls one clock after `ext_req` is seen low. A request raised during a cycle defers the grant until after T4.
- R10: A request taken in the first half of T4 starts the new cycle's lead half in the very next clock, presenting its kind on `cyc_status`.
- R11: After reset, all strobes are inactive, `cyc_status` is 111, `ext_grant` is low, `ctl_oe` is high and `ad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A bus request is presented |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| bus_rdy | input | 1 | Low to stretch the cycle with wait states |
| ext_req | input | 1 | External master asks for the bus |
| req_accept | output | 1 | Request is taken at this edge |
| addr_strobe | output | 1 | Address latch pulse |
| rd_strb_n | output | 1 | Read strobe, active low |
| wr_strb_n | output | 1 | Write strobe, active low |
| ack_strb_n | output | 1 | Interrupt acknowledge strobe, active low |
| xcvr_en_n | output | 1 | Data transceiver enable, active low |
| xcvr_tx | output | 1 | Transceiver direction, 1 = transmit |
| mem_sel | output | 1 | 1 = memory, 0 = I/O |
| cyc_status | output | 3 | Cycle status code |
| ad_out | output | DATA_W | Multiplexed address/data out |
| ad_oe | output | 1 | Output enable for ad_out and a_hi |
| a_hi | output | ADDR_W-DATA_W | Upper address lines |
| ctl_oe | output | 1 | Output enable for strobes and status |
| ext_grant | output | 1 | Bus granted to the external master |

## Verification
The bench sweeps all seven kinds against zero, one and two wait states and compares every half-state against windows derived from the wait count. A design off by one half-state would misplace the transceiver enable by half a T-state, or would leave status active into T4. A back-to-back pair checks that the second cycle's lead half and status appear directly after the first half of T4. A wrong acceptance window would instead insert idle states or corrupt the first cycle's tail. A hold raised during a cycle checks that the grant waits for idle and that the output enables then drop, and a kind of 111 checks that no cycle starts from it.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_T1, S_T2, S_T3, S_TW, S_T4, S_HOLD
  } bstate_e;

  localparam logic [2:0] K_ACK  = 3'b000;
  localparam logic [2:0] K_IORD = 3'b001;
  localparam logic [2:0] K_IOWR = 3'b010;
  localparam logic [2:0] K_HALT = 3'b011;
  localparam logic [2:0] K_CODE = 3'b100;
  localparam logic [2:0] K_MRD  = 3'b101;
  localparam logic [2:0] K_MWR  = 3'b110;
  localparam logic [2:0] K_PASS = 3'b111;

  function automatic logic kind_rd(input logic [2:0] k);
    return (k == K_IORD) || (k == K_CODE) || (k == K_MRD);
  endfunction

  function automatic logic kind_wr(input logic [2:0] k);
    return (k == K_IOWR) || (k == K_MWR);
  endfunction

  function automatic logic kind_ack(input logic [2:0] k);
    return k == K_ACK;
  endfunction

endpackage

// File: rtl/bsg_seq.sv
module bsg_seq
  import bsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  input  logic       bus_rdy,
  input  logic       ext_req,
  output bstate_e    st,
  output logic       ph,
  output logic       rdy_q,
  output logic       take
);

  bstate_e st_d;
  logic    rdy_en;

  always_comb begin
    take   = req_valid && (req_kind != K_PASS) && !ext_req && !ph &&
             ((st == S_IDLE) || (st == S_T4));
    rdy_en = !ph && ((st == S_T3) || (st == S_TW));
    st_d   = st;
    case (st)
      S_IDLE: if (!ph) begin
                if (ext_req)   st_d = S_HOLD;
                else if (take) st_d = S_LEAD;
              end
      S_LEAD: st_d = S_T1;
      S_T1:   if (ph) st_d = S_T2;
      S_T2:   if (ph) st_d = S_T3;
      S_T3,
      S_TW:   if (ph) st_d = rdy_q ? S_T4 : S_TW;
      S_T4:   if (take)    st_d = S_LEAD;
              else if (ph) st_d = S_IDLE;
      S_HOLD: if (!ext_req) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ph    <= 1'b0;
      rdy_q <= 1'b1;
    end else begin
      st <= st_d;
      ph <= ~ph;
      if (rdy_en) rdy_q <= bus_rdy;
    end
  end

endmodule

// File: rtl/bsg_req_latch.sv
module bsg_req_latch
  import bsg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [2:0]        kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_PASS;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      kind_q  <= req_kind;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

endmodule

// File: rtl/bsg_decode.sv
module bsg_decode
  import bsg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  bstate_e           st,
  input  logic              ph,
  input  logic              rdy_q,
  input  logic [2:0]        kind_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic              addr_strobe,
  output logic              rd_strb_n,
  output logic              wr_strb_n,
  output logic              ack_strb_n,
  output logic              xcvr_en_n,
  output logic              xcvr_tx,
  output logic              mem_sel,
  output logic [2:0]        cyc_status,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              ctl_oe,
  output logic              ext_grant
);

  logic is_rd, is_wr, is_ack, moves, data_ph, den_win;

  always_comb begin
    is_rd   = kind_rd(kind_q);
    is_wr   = kind_wr(kind_q);
    is_ack  = kind_ack(kind_q);
    moves   = is_rd || is_wr || is_ack;
    data_ph = (st == S_T2) || (st == S_T3) || (st == S_TW);
    den_win = ((st == S_T2) && (ph || is_wr)) || (st == S_T3) ||
              (st == S_TW) || ((st == S_T4) && !ph);

    addr_strobe = (st == S_T1) && !ph;
    rd_strb_n   = !(data_ph && is_rd);
    wr_strb_n   = !(data_ph && is_wr);
    ack_strb_n  = !(data_ph && is_ack);
    xcvr_en_n   = !(moves && den_win);
    xcvr_tx     = is_wr;
    mem_sel     = kind_q[2];

    case (st)
      S_LEAD, S_T1, S_T2: cyc_status = kind_q;
      S_T3, S_TW:         cyc_status = (ph && rdy_q) ? K_PASS : kind_q;
      default:            cyc_status = K_PASS;
    endcase

    ad_oe     = (st == S_T1) || (is_wr && (data_ph || (st == S_T4)));
    ad_out    = (st == S_T1) ? addr_q[DATA_W-1:0] : wdata_q;
    ctl_oe    = (st != S_HOLD);
    ext_grant = (st == S_HOLD);
  end

  for (genvar i = 0; i < HI_W; i++) begin : g_hi
    assign a_hi[i] = (st == S_T1) && kind_q[2] && addr_q[DATA_W+i];
  end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bsg_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     bus_rdy,
  input  logic                     ext_req,
  output logic                     req_accept,
  output logic                     addr_strobe,
  output logic                     rd_strb_n,
  output logic                     wr_strb_n,
  output logic                     ack_strb_n,
  output logic                     xcvr_en_n,
  output logic                     xcvr_tx,
  output logic                     mem_sel,
  output logic [2:0]               cyc_status,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     ctl_oe,
  output logic                     ext_grant
);

  logic [1:0]        rst_pipe;
  logic              rst_s_n;
  bstate_e           st;
  logic              ph, rdy_q, take;
  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  bsg_seq u_seq (
    .clk(clk), .rst_n(rst_s_n), .req_valid(req_valid), .req_kind(req_kind),
    .bus_rdy(bus_rdy), .ext_req(ext_req), .st(st), .ph(ph), .rdy_q(rdy_q),
    .take(take)
  );

  bsg_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_s_n), .take(take), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .kind_q(kind_q),
    .addr_q(addr_q), .wdata_q(wdata_q)
  );

  bsg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .st(st), .ph(ph), .rdy_q(rdy_q), .kind_q(kind_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .addr_strobe(addr_strobe), .rd_strb_n(rd_strb_n),
    .wr_strb_n(wr_strb_n), .ack_strb_n(ack_strb_n), .xcvr_en_n(xcvr_en_n),
    .xcvr_tx(xcvr_tx), .mem_sel(mem_sel), .cyc_status(cyc_status),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ctl_oe(ctl_oe),
    .ext_grant(ext_grant)
  );

  assign req_accept = take;

endmodule

// File: rtl/bsg_checker.sv
module bsg_checker
  import bsg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_accept,
  input logic       addr_strobe,
  input logic       rd_strb_n,
  input logic       wr_strb_n,
  input logic       ack_strb_n,
  input logic       xcvr_en_n,
  input logic [2:0] cyc_status,
  input logic       ad_oe,
  input logic       ctl_oe,
  input logic       ext_grant,
  input bstate_e    st
);

  // R2: the strobe lasts one half-state
  a_r2_strobe_half: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !addr_strobe);

  // R2: a taken request reaches the address strobe after the lead half
  a_r2_lead_then_t1: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> !addr_strobe ##1 addr_strobe);

  // R3: at most one data strobe active
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rd_strb_n, ~wr_strb_n, ~ack_strb_n}) <= 1);

  // R4: the transceiver is enabled whenever a write is strobed
  a_r4_en_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strb_n |-> !xcvr_en_n);

  // R6: status is active while the address is strobed
  a_r6_status_in_t1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |-> cyc_status != 3'b111);

  // R9: a grant floats the bus and keeps the address strobe low
  a_r9_float: assert property (@(posedge clk) disable iff (!rst_n)
    ext_grant |-> (!ctl_oe && !ad_oe && !addr_strobe && !req_accept));

  // R9: a grant starts only from idle
  a_r9_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_grant) |-> $past(st) == S_IDLE);

endmodule

bind bus_strobe_gen bsg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_accept(req_accept),
  .addr_strobe(addr_strobe), .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n),
  .ack_strb_n(ack_strb_n), .xcvr_en_n(xcvr_en_n), .cyc_status(cyc_status),
  .ad_oe(ad_oe), .ctl_oe(ctl_oe), .ext_grant(ext_grant), .st(st)
);

// File: tb/tb_bus_strobe_gen.sv
module tb_bus_strobe_gen;

  logic        clk = 1'b0;
  logic        rst_n, req_valid, bus_rdy, ext_req;
  logic [2:0]  req_kind;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_accept, addr_strobe, rd_strb_n, wr_strb_n, ack_strb_n;
  logic        xcvr_en_n, xcvr_tx, mem_sel, ad_oe, ctl_oe, ext_grant;
  logic [2:0]  cyc_status;
  logic [15:0] ad_out;
  logic [3:0]  a_hi;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .bus_rdy(bus_rdy),
    .ext_req(ext_req), .req_accept(req_accept), .addr_strobe(addr_strobe),
    .rd_strb_n(rd_strb_n), .wr_strb_n(wr_strb_n), .ack_strb_n(ack_strb_n),
    .xcvr_en_n(xcvr_en_n), .xcvr_tx(xcvr_tx), .mem_sel(mem_sel),
    .cyc_status(cyc_status), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
    .ctl_oe(ctl_oe), .ext_grant(ext_grant)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [2:0] k, input logic [19:0] a, input logic [15:0] d,
                           input int w, input bit pre, input bit hold_mid, input bit chain,
                           input logic [2:0] nk, input logic [19:0] na, input logic [15:0] nd);
    bit is_rd, is_wr, is_ak, mv, e_str, e_oe;
    int last;
    is_rd = (k == 3'd1) || (k == 3'd4) || (k == 3'd5);
    is_wr = (k == 3'd2) || (k == 3'd6);
    is_ak = (k == 3'd0);
    mv    = is_rd || is_wr || is_ak;
    last  = chain ? 7 + 2*w : 8 + 2*w;
    if (!pre) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
      #1;
      while (!req_accept) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    for (int h = 0; h <= last; h++) begin
      @(negedge clk);
      if (h == 0) req_valid = 1'b0;
      #1;
      e_str = (h >= 3) && (h <= 6 + 2*w);
      e_oe  = (h == 1) || (h == 2) || (is_wr && h >= 3);
      chk("R2 addr_strobe", addr_strobe, h == 1);
      chk("R3 rd_strb_n", rd_strb_n, !(e_str && is_rd));
      chk("R3 wr_strb_n", wr_strb_n, !(e_str && is_wr));
      chk("R3 ack_strb_n", ack_strb_n, !(e_str && is_ak));
      chk("R4 xcvr_en_n", xcvr_en_n,
          !(mv && h <= 7 + 2*w && (h >= 4 || (is_wr && h >= 3))));
      if (h <= 7 + 2*w) begin
        chk("R5 mem_sel", mem_sel, k[2]);
        chk("R5 xcvr_tx", xcvr_tx, is_wr);
      end
      chk("R6 cyc_status", cyc_status, (h <= 5 + 2*w) ? k : 3'b111);
      chk("R8 ad_oe", ad_oe, e_oe);
      if (e_oe) chk("R8 ad_out", ad_out, (h <= 2) ? a[15:0] : d);
      if (h == 1) chk("R8 a_hi", a_hi, k[2] ? a[19:16] : 4'h0);
      if (h == 0 && pre) chk("R10 chained lead status", cyc_status, k);
      if (mv && h == 6 + 2*w) chk("R7 strobe still on at last wait", {rd_strb_n, wr_strb_n, ack_strb_n}, {!is_rd, !is_wr, !is_ak});
      if (h == 7 + 2*w) chk("R7 strobes off in T4", {rd_strb_n, wr_strb_n, ack_strb_n}, 3'b111);
      chk("R9 no grant during cycle", ext_grant, 1'b0);
      bus_rdy = !(h >= 5 && ((h - 5) / 2) < w);
      if (hold_mid && h == 3) ext_req = 1'b1;
      if (chain && h == 7 + 2*w) begin
        req_valid = 1'b1; req_kind = nk; req_addr = na; req_wdata = nd;
        #1;
        chk("R10 accept in T4", req_accept, 1'b1);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; bus_rdy = 1'b1; ext_req = 1'b0;
    req_kind = 3'b111; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 status", cyc_status, 3'b111);
    chk("R11 strobes", {addr_strobe, rd_strb_n, wr_strb_n, ack_strb_n, xcvr_en_n}, 5'b01111);
    chk("R11 grant", ext_grant, 1'b0);
    chk("R11 enables", {ctl_oe, ad_oe}, 2'b10);

    // R1: kind 111 never starts a cycle
    req_valid = 1'b1; req_kind = 3'b111;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      chk("R1 passive kind not taken", req_accept, 1'b0);
      chk("R1 no strobe from passive kind", addr_strobe, 1'b0);
    end
    req_valid = 1'b0;

    // sweep every kind against 0..2 wait states
    for (int k = 0; k < 7; k++) begin
      for (int w = 0; w < 3; w++) begin
        run_cycle(3'(k), 20'((k + 9) * 65536 + k * 4099 + w * 257),
                  16'(16'hA5C3 ^ (k * 16'h1111) ^ w), w, 1'b0, 1'b0, 1'b0,
                  3'd0, 20'd0, 16'd0);
        repeat (2) @(negedge clk);
      end
    end

    // R10: memory write chained into an I/O read
    run_cycle(3'd6, 20'hB1234, 16'h5A5A, 1, 1'b0, 1'b0, 1'b1, 3'd1, 20'h0F00F, 16'h0);
    run_cycle(3'd1, 20'h0F00F, 16'h0, 0, 1'b1, 1'b0, 1'b0, 3'd0, 20'd0, 16'd0);
    repeat (2) @(negedge clk);

    // R9: hold raised mid-cycle waits for the cycle end
    run_cycle(3'd5, 20'h3C0DE, 16'h0, 1, 1'b0, 1'b1, 1'b0, 3'd0, 20'd0, 16'd0);
    @(negedge clk); #1;
    chk("R9 grant deferred to idle", ext_grant, 1'b0);
    @(negedge clk); #1;
    chk("R9 grant in mid idle", ext_grant, 1'b1);
    chk("R9 float", {ctl_oe, ad_oe, addr_strobe}, 3'b000);
    req_valid = 1'b1; req_kind = 3'd4; req_addr = 20'h12345; req_wdata = 16'h0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R1 no take during hold", req_accept, 1'b0);
      chk("R9 grant held", ext_grant, 1'b1);
    end
    ext_req = 1'b0;
    @(negedge clk); #1;
    chk("R9 grant released", ext_grant, 1'b0);
    chk("R9 enables back", ctl_oe, 1'b1);
    run_cycle(3'd4, 20'h12345, 16'h0, 2, 1'b0, 1'b0, 1'b0, 3'd0, 20'd0, 16'd0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule